// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with One-Time Lower-Half Lock

This block is a synthesizable model of a 256-byte serial memory that answers as a slave on a two-wire bus. SDA is open-drain: the block only pulls it low. SCL is sampled and never held. A system clock oversamples both lines through two-flop synchronizers. From the bus it decodes start and stop conditions, a device-select byte, a one-byte word address and a stream of data bytes. The array is an internal register file.

Writes go into a page buffer of 16 bytes. The buffered bytes reach the array only when the master sends a stop. A self-timed busy interval then follows, and during it the block stays silent on the bus so the master can poll for completion. Reads can start at an address set by a dummy write followed by a repeated start, and they carry on for as long as the master acknowledges.

A dedicated lock command sets a protection latch. No bus command can clear it. Once it is set, addresses 0 to 127 accept data bytes on the bus but never change. A write-protect input blocks every write, the lock command included.

Top module: `twowire_eeprom`

## Requirements
- R1: A select byte is acknowledged (SDA pulled low for the ninth clock) only when it equals {4'b1010, CHIP_SEL, rw} or the lock form {4'b0110, CHIP_SEL, 1'b0}. Any other select byte, for example 8'hA2 with the default CHIP_SEL of 3'b000, is not acknowledged. The block pulls SDA low only while SCL is low.
- R2: After reset every array byte reads 8'hFF, the lock latch is clear, no busy interval is running and SDA is released.
- R3: A write is a select with rw=0, then an address byte, then one or more data bytes, then a stop. Every byte is acknowledged. After the stop exactly the received bytes land at their addresses, and the other bytes of the page keep their values.
- R4: During a write the low 4 address bits step up after each data byte and wrap inside the 16-byte page. The upper 4 bits do not move. When more than 16 bytes are sent, the later bytes replace the earlier ones in the same slots.
- R5: If the write-protect input is high at the stop, no array byte changes and no busy interval begins. A select sent straight afterwards is acknowledged.
- R6: A stop that ends a write carrying at least one data byte, with write-protect low, starts a busy interval of WRITE_CLKS system clocks. The same holds for an accepted lock command. While busy, every select byte goes unacknowledged. Once the interval ends, selects are acknowledged again.
- R7: A random read returns the byte at the address set by the dummy write: select with rw=0, address byte, repeated start, select with rw=1.
- R8: A read delivers bytes at consecutive addresses while the master acknowledges, rolling from 255 to 0. A master not-acknowledge ends the transfer and releases SDA.
- R9: The lock command is the lock select, any following bytes (all acknowledged), then a stop. With write-protect low it sets the latch. After that, data bytes aimed at addresses 0 to 127 are acknowledged but not stored, while addresses 128 to 255 stay writable. With write-protect high at the stop, the latch stays clear.
- R10: Once the latch is set it never clears from the bus, and any further lock select goes unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Level of the serial clock line |
| sdaIn | input | 1 | Level of the serial data line (wired-AND with the block's own drive) |
| wpIn | input | 1 | Write-protect: high blocks every write and the lock command |
| sdaDrvLow | output | 1 | High pulls the data line low; low releases it |

## Verification
The checks assume the master changes SDA only while SCL is low, except for start and stop. They also assume each SCL half-period spans several system clocks, enough to cover the synchronizer delay, and that write-protect holds steady across each stop. The bench bit-bangs the bus with a quarter-period of six system clocks. It moves SDA only in the middle of a low SCL phase and changes write-protect only between transactions. Random write lengths, addresses and data are drawn from a fixed seed and mixed with directed cases for page wrap, address rollover, write-protect and the lock command.

// File: rtl/twowire_eeprom_pkg.sv
package twowire_eeprom_pkg;
  localparam int ADDR_W = 8;
  localparam logic [3:0] MEM_TYPE  = 4'b1010;
  localparam logic [3:0] LOCK_TYPE = 4'b0110;

  typedef struct packed {
    logic clearBuf;
    logic loadAddr;
    logic pushByte;
    logic nextRd;
    logic commit;
    logic armLock;
  } dpStrobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK} busState_t;
  typedef enum logic [1:0] {PH_DEV, PH_ADDR, PH_DATA} rxPhase_t;
endpackage

// File: rtl/twowire_eeprom_ctrl.sv
module twowire_eeprom_ctrl
  import twowire_eeprom_pkg::*;
#(
  parameter logic [2:0] CHIP_SEL = 3'b000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      busy,
  input  logic      locked,
  input  logic [7:0] rdByte,
  output logic [7:0] rxByte,
  output dpStrobe_t strb,
  output logic      sdaDrvLow
);
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  busState_t  state;
  rxPhase_t   phase;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       wrMode, rdMode, isLock, mAck, sdaLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  logic sclHi, sdaHi, sclRise, sclFall, startCond, stopCond;
  logic memMatch, lockMatch, selAck;
  assign sclHi     = sclSync[1];
  assign sdaHi     = sdaSync[1];
  assign sclRise   = sclHi & ~sclPrev;
  assign sclFall   = ~sclHi & sclPrev;
  assign startCond = sclHi & sclPrev & sdaPrev & ~sdaHi;
  assign stopCond  = sclHi & sclPrev & ~sdaPrev & sdaHi;
  assign memMatch  = (shReg[7:1] == {MEM_TYPE, CHIP_SEL});
  assign lockMatch = (shReg == {LOCK_TYPE, CHIP_SEL, 1'b0});
  assign selAck    = !busy && (memMatch || (lockMatch && !locked));
  assign rxByte    = shReg;
  assign sdaDrvLow = sdaLow;

  always_comb begin
    strb = '0;
    if (startCond) strb.clearBuf = 1'b1;
    else if (stopCond) begin
      strb.commit  = wrMode & ~isLock;
      strb.armLock = isLock;
    end else if (sclFall && bitCnt == 4'd8) begin
      if (state == ST_RECV && !isLock) begin
        strb.loadAddr = (phase == PH_ADDR);
        strb.pushByte = (phase == PH_DATA);
      end
      if (state == ST_SEND) strb.nextRd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= PH_DEV; bitCnt <= '0; shReg <= '0;
      wrMode <= 1'b0; rdMode <= 1'b0; isLock <= 1'b0; mAck <= 1'b0; sdaLow <= 1'b0;
    end else if (startCond) begin
      state <= ST_RECV; phase <= PH_DEV; bitCnt <= '0; sdaLow <= 1'b0;
      wrMode <= 1'b0; rdMode <= 1'b0; isLock <= 1'b0;
    end else if (stopCond) begin
      state <= ST_IDLE; sdaLow <= 1'b0;
      wrMode <= 1'b0; rdMode <= 1'b0; isLock <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise) begin
            shReg  <= {shReg[6:0], sdaHi};
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (phase != PH_DEV) begin
              sdaLow <= 1'b1; state <= ST_ACK;
            end else if (selAck) begin
              sdaLow <= 1'b1; state <= ST_ACK;
              isLock <= lockMatch;
              wrMode <= memMatch & ~shReg[0];
              rdMode <= memMatch & shReg[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (rdMode) begin
              shReg <= rdByte; sdaLow <= ~rdByte[7]; state <= ST_SEND;
            end else begin
              sdaLow <= 1'b0; state <= ST_RECV;
              phase  <= (phase == PH_DEV) ? PH_ADDR : PH_DATA;
            end
          end
        end
        ST_SEND: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaLow <= 1'b0; state <= ST_MACK;
            end else begin
              sdaLow <= ~shReg[6];
              shReg  <= {shReg[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAck <= ~sdaHi;
          else if (sclFall) begin
            if (mAck) begin
              shReg <= rdByte; sdaLow <= ~rdByte[7]; bitCnt <= '0; state <= ST_SEND;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twowire_eeprom_dpath.sv
module twowire_eeprom_dpath
  import twowire_eeprom_pkg::*;
#(
  parameter int WRITE_CLKS = 250000,
  parameter int PAGE_W     = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wpIn,
  input  dpStrobe_t strb,
  input  logic [7:0] rxByte,
  output logic [7:0] rdByte,
  output logic      busy,
  output logic      locked
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CLKS + 1);

  logic [7:0]            mem     [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [ADDR_W-1:0]     curAddr;
  logic [CNT_W-1:0]      busyCnt;

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [ADDR_W-1:0] base, input int idx);
    return {base[ADDR_W-1:PAGE_W], PAGE_W'(idx)};
  endfunction

  // lower half of the array is the region the latch freezes
  function automatic logic isShielded(input logic [ADDR_W-1:0] a, input logic lk);
    return lk && !a[ADDR_W-1];
  endfunction

  assign rdByte = mem[curAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
      bufValid <= '0; curAddr <= '0; locked <= 1'b0; busy <= 1'b0; busyCnt <= '0;
    end else begin
      if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else busyCnt <= busyCnt - 1'b1;
      end
      if (strb.clearBuf) bufValid <= '0;
      if (strb.loadAddr) curAddr <= rxByte;
      if (strb.pushByte) begin
        pageBuf[curAddr[PAGE_W-1:0]]  <= rxByte;
        bufValid[curAddr[PAGE_W-1:0]] <= 1'b1;
        curAddr[PAGE_W-1:0]           <= curAddr[PAGE_W-1:0] + 1'b1;
      end
      if (strb.nextRd) curAddr <= curAddr + 1'b1;
      if (strb.commit) begin
        bufValid <= '0;
        if (|bufValid && !wpIn) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (bufValid[i] && !isShielded(slotAddr(curAddr, i), locked))
              mem[slotAddr(curAddr, i)] <= pageBuf[i];
          busy    <= 1'b1;
          busyCnt <= CNT_W'(WRITE_CLKS - 1);
        end
      end
      if (strb.armLock && !wpIn && !locked) begin
        locked  <= 1'b1;
        busy    <= 1'b1;
        busyCnt <= CNT_W'(WRITE_CLKS - 1);
      end
    end
  end
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twowire_eeprom_pkg::*;
#(
  parameter int         WRITE_CLKS = 250000,
  parameter int         PAGE_W     = 4,
  parameter logic [2:0] CHIP_SEL   = 3'b000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaDrvLow
);
  dpStrobe_t  strb;
  logic [7:0] rxByte, rdByte;
  logic       busyW, lockedW;

  twowire_eeprom_ctrl #(.CHIP_SEL(CHIP_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .busy(busyW), .locked(lockedW), .rdByte(rdByte),
    .rxByte(rxByte), .strb(strb), .sdaDrvLow(sdaDrvLow)
  );

  twowire_eeprom_dpath #(.WRITE_CLKS(WRITE_CLKS), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .strb(strb), .rxByte(rxByte),
    .rdByte(rdByte), .busy(busyW), .locked(lockedW)
  );
endmodule

// File: rtl/twowire_eeprom_chk.sv
module twowire_eeprom_chk
  import twowire_eeprom_pkg::*;
#(
  parameter int WRITE_CLKS = 250000
) (
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaDrvLow,
  input logic      wpIn,
  input logic      busy,
  input logic      locked,
  input dpStrobe_t strb
);
  int busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else busyRun <= busy ? busyRun + 1 : 0;
  end

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclIn); // R1
  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && wpIn) |=> !busy); // R5
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDrvLow); // R6
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < WRITE_CLKS)); // R6
  AST_LOCK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(strb.armLock) && !$past(wpIn))); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R10
endmodule

bind twowire_eeprom twowire_eeprom_chk #(.WRITE_CLKS(WRITE_CLKS)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow), .wpIn(wpIn),
  .busy(busyW), .locked(lockedW), .strb(strb)
);

// File: tb/twowire_eeprom_test.sv
module twowire_eeprom_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q    = 6;
  localparam int WCLK = 300;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, wpIn = 1'b0;
  logic sdaDrvLow, sdaLine;
  assign sdaLine = sdaM & ~sdaDrvLow;

  twowire_eeprom #(.WRITE_CLKS(WCLK)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .wpIn(wpIn), .sdaDrvLow(sdaDrvLow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChk = 0, nFail = 0;
  logic [7:0] expMem [256];
  bit expLocked = 1'b0;
  logic [7:0] wrData [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nChk++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] slotOf(input logic [7:0] base, input int k);
    return {base[7:4], base[3:0] + 4'(k)};
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic clkBit(input logic b, output logic s);
    wq(); sdaM = b; wq(); sclM = 1'b1; wq(); s = sdaLine; wq(); sclM = 1'b0;
  endtask

  task automatic busStart();
    wq(); sdaM = 1'b1; wq(); sclM = 1'b1; wq(); sdaM = 1'b0; wq(); sclM = 1'b0;
  endtask

  task automatic busStop();
    wq(); sdaM = 1'b0; wq(); sclM = 1'b1; wq(); sdaM = 1'b1; wq();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s);
    clkBit(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin clkBit(1'b1, s); v[i] = s; end
    clkBit(!mack, s);
  endtask

  task automatic pollBusy(input string req);
    bit ack;
    busStart(); sendByte(8'hA0, ack); busStop();
    chk({req, " R6 select ignored while busy"}, ack, 0);
    repeat (WCLK) @(negedge clk);
    busStart(); sendByte(8'hA0, ack); busStop();
    chk({req, " R6 select answered after interval"}, ack, 1);
  endtask

  task automatic writeSeq(input logic [7:0] addr, input int n, input bit wp, input string req);
    bit ack;
    wpIn = wp;
    busStart();
    sendByte(8'hA0, ack); chk({req, " R1 select ack"}, ack, 1);
    sendByte(addr, ack);  chk({req, " R3 address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(wrData[k], ack); chk({req, " R3 data ack"}, ack, 1);
    end
    busStop();
    if (!wp && n > 0) begin
      for (int k = 0; k < n; k++)
        if (!(expLocked && !slotOf(addr, k)[7])) expMem[slotOf(addr, k)] = wrData[k];
      pollBusy(req);
    end else begin
      busStart(); sendByte(8'hA0, ack); busStop();
      chk({req, " R5 no busy interval"}, ack, 1);
    end
    wpIn = 1'b0;
  endtask

  task automatic readSeq(input logic [7:0] addr, input int n, input string req);
    bit ack;
    logic [7:0] v;
    busStart();
    sendByte(8'hA0, ack); sendByte(addr, ack);
    busStart();
    sendByte(8'hA1, ack); chk({req, " R7 read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, v);
      chk({req, " R8 read data"}, v, expMem[8'(addr + k)]);
    end
    busStop();
  endtask

  task automatic lockCmd(input bit wp);
    bit ack;
    wpIn = wp;
    busStart();
    sendByte(8'h60, ack); chk("R9 lock select ack", ack, 1);
    sendByte(8'h00, ack); chk("R9 lock byte ack", ack, 1);
    sendByte(8'h00, ack);
    busStop();
    if (!wp) begin
      expLocked = 1'b1;
      pollBusy("R9 lock");
    end else begin
      busStart(); sendByte(8'hA0, ack); busStop();
      chk("R5 blocked lock starts no interval", ack, 1);
    end
    wpIn = 1'b0;
  endtask

  task automatic randomRound(input string req);
    logic [7:0] a;
    int n;
    bit wp;
    a  = 8'($urandom % 256);
    n  = 1 + ($urandom % 16);
    wp = (($urandom % 4) == 0);
    for (int k = 0; k < n; k++) wrData[k] = 8'($urandom);
    writeSeq(a, n, wp, req);
    readSeq({a[7:4], 4'h0}, 16, req);
  endtask

  initial begin
    bit ack;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) expMem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    chk("R2 data line released", sdaDrvLow, 0);
    readSeq(8'h37, 1, "R2 erased");
    readSeq(8'hC8, 2, "R2 erased");

    busStart(); sendByte(8'hA2, ack); busStop();
    chk("R1 foreign chip select", ack, 0);
    busStart(); sendByte(8'h61, ack); busStop();
    chk("R1 lock form with read bit", ack, 0);

    wrData[0] = 8'hA5;
    writeSeq(8'h10, 1, 1'b0, "R3 single");
    readSeq(8'h10, 1, "R7 random");

    for (int k = 0; k < 5; k++) wrData[k] = 8'h30 + 8'(k);
    writeSeq(8'h23, 5, 1'b0, "R3 partial page");
    readSeq(8'h20, 16, "R3 partial page");

    for (int k = 0; k < 18; k++) wrData[k] = 8'h80 + 8'(k);
    writeSeq(8'h4E, 18, 1'b0, "R4 wrap");
    readSeq(8'h40, 16, "R4 wrap");

    wrData[0] = 8'h11; wrData[1] = 8'h22;
    writeSeq(8'hFE, 2, 1'b0, "R8 top");
    wrData[0] = 8'h33; wrData[1] = 8'h44;
    writeSeq(8'h00, 2, 1'b0, "R8 bottom");
    readSeq(8'hFE, 4, "R8 rollover");

    for (int k = 0; k < 4; k++) wrData[k] = 8'h5A;
    writeSeq(8'h60, 4, 1'b1, "R5 protect pin");
    readSeq(8'h60, 4, "R5 unchanged");

    for (int r = 0; r < 5; r++) randomRound("R3 random");

    lockCmd(1'b1);
    wrData[0] = 8'h77;
    writeSeq(8'h05, 1, 1'b0, "R9 still open");
    readSeq(8'h05, 1, "R9 still open");

    lockCmd(1'b0);
    wrData[0] = 8'hC3;
    writeSeq(8'h05, 1, 1'b0, "R9 shielded");
    readSeq(8'h05, 1, "R9 shielded");
    wrData[0] = 8'h3C; wrData[1] = 8'h4D;
    writeSeq(8'h7F, 2, 1'b0, "R9 boundary");
    readSeq(8'h70, 16, "R9 boundary");
    wrData[0] = 8'h96;
    writeSeq(8'h85, 1, 1'b0, "R9 upper");
    readSeq(8'h85, 1, "R9 upper");

    busStart(); sendByte(8'h60, ack); busStop();
    chk("R10 second lock refused", ack, 0);
    busStart(); sendByte(8'hA0, ack); busStop();
    chk("R10 memory select still answered", ack, 1);

    for (int r = 0; r < 3; r++) randomRound("R9 random");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule